// File: doc/BRIEF.md
# TLB Random Index Generator

This block supplies a pseudo-random replacement slot for a translation lookaside buffer that software refills. The lowest entries of the buffer can be reserved ("wired") so that they are never replaced. Every index the block returns therefore lies between the wired count and the last entry. A 32-bit linear congruential state steps once for each accepted request. The upper half of the new state is reduced modulo the number of unwired entries, and the wired count is added to the result.

A request is a one-cycle strobe on `req_i`, sampled together with `wired_i` while the block is idle. The reduction uses a bit-serial restoring divider, so a result takes a fixed number of cycles. The result appears on `index_o` together with a one-cycle `valid_o` pulse. Requests that arrive while a result is being computed are dropped.

The controller has four states:
- `ST_IDLE` waits for a request. On a request it steps the state, latches the wired count and moves to `ST_LOAD`.
- `ST_LOAD` starts the divider and moves to `ST_DIVIDE` when the wired count is legal. Otherwise it goes straight to `ST_FINISH`.
- `ST_DIVIDE` runs one quotient bit per cycle and moves to `ST_FINISH` on the last bit.
- `ST_FINISH` registers the index, raises the valid pulse and returns to `ST_IDLE`.

Top module: `tlb_rand_index`

## Requirements
- R1: A synchronous active-high reset sets the 32-bit state to zero, drives `valid_o` low and drives `index_o` to 0.
- R2: Each accepted request (req_i high while idle) replaces the state s with (s * 314159 + 1) mod 2^32, exactly once per request, before the index is derived.
- R3: For a legal wired count w (w < TLB_SIZE), the index equals (bits 31..16 of the updated state) mod (TLB_SIZE - w), plus w.
- R4: Every reported index lies within w .. TLB_SIZE-1 when w is legal, and never exceeds TLB_SIZE-1.
- R5: When w >= TLB_SIZE, the reported index is TLB_SIZE-1. The state still steps, and `valid_o` rises 2 cycles after the sampling edge.
- R6: For a legal w, `valid_o` rises 18 clock edges after the edge that accepted the request (16 divider steps plus two control cycles).
- R7: `valid_o` is high for exactly one cycle per accepted request.
- R8: A request that arrives while a result is in progress is ignored. It does not step the state and does not produce a pulse.
- R9: The wired count is sampled only at acceptance. Changes to `wired_i` during the computation do not alter the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 1 | Request strobe for a new index |
| wired_i | input | WIRED_W (5) | Number of reserved low entries |
| index_o | output | IDX_W (4) | Replacement index |
| valid_o | output | 1 | One-cycle pulse when `index_o` is new |

## Verification
A result for a legal wired count is due on the 18th rising edge after the edge that sampled the request. For an illegal count it is due on the 2nd such edge. The bench raises the strobe on a falling edge and counts falling edges until `valid_o` appears. It checks that the count equals the expected latency exactly, which catches both early and late pulses. On the following falling edge it confirms the pulse has ended. Noise requests and wired changes are injected only in the middle of the divide window, and the effect of that noise is judged through the indices of later requests, which follow a state sequence the bench computes itself.

// File: rtl/tlb_rand_pkg.sv
package tlb_rand_pkg;

    localparam int unsigned SEED_W   = 32;
    localparam int unsigned HALF_W   = SEED_W / 2;
    localparam logic [SEED_W-1:0] LCG_MULT = 32'd314159;
    localparam logic [SEED_W-1:0] LCG_INC  = 32'd1;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOAD   = 2'd1,
        ST_DIVIDE = 2'd2,
        ST_FINISH = 2'd3
    } rnd_state_e;

endpackage

// File: rtl/tlb_rand_lcg.sv
module tlb_rand_lcg #(
    parameter int unsigned       W    = 32,
    parameter logic [W-1:0]      MULT = 32'd314159,
    parameter logic [W-1:0]      INC  = 32'd1
) (
    input  logic [W-1:0] seed_i,
    output logic [W-1:0] seed_next_o
);

    // Product truncates naturally to W bits: arithmetic is mod 2^W.
    always_comb begin
        seed_next_o = seed_i * MULT + INC;
    end

endmodule

// File: rtl/tlb_rand_moddiv.sv
module tlb_rand_moddiv #(
    parameter int unsigned NUM_W = 16,
    parameter int unsigned DEN_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [NUM_W-1:0] num_i,
    input  logic [DEN_W-1:0] den_i,
    output logic             last_o,
    output logic [DEN_W-1:0] rem_o
);

    localparam int unsigned CNT_W  = $clog2(NUM_W + 1);
    localparam int unsigned PART_W = DEN_W + 1;

    logic [DEN_W-1:0]  rem_q;
    logic [NUM_W-1:0]  quo_q;
    logic [DEN_W-1:0]  den_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [PART_W-1:0] partial;
    logic [PART_W-1:0] diff;
    logic              take;

    // One restoring step: shift in the next dividend bit, subtract when possible.
    always_comb begin
        partial = {rem_q, quo_q[NUM_W-1]};
        diff    = partial - {1'b0, den_q};
        take    = (partial >= {1'b0, den_q});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
            quo_q <= '0;
            den_q <= '0;
            cnt_q <= '0;
        end else if (load_i) begin
            rem_q <= '0;
            quo_q <= num_i;
            den_q <= den_i;
            cnt_q <= CNT_W'(NUM_W);
        end else if (cnt_q != '0) begin
            rem_q <= take ? DEN_W'(diff) : DEN_W'(partial);
            quo_q <= {quo_q[NUM_W-2:0], take};
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last_o = (cnt_q == CNT_W'(1));
    assign rem_o  = rem_q;

endmodule

// File: rtl/tlb_rand_map.sv
module tlb_rand_map #(
    parameter int unsigned TLB_SIZE = 16,
    parameter int unsigned WIRED_W  = 5,
    parameter int unsigned SPAN_W   = 5,
    parameter int unsigned IDX_W    = 4
) (
    input  logic [WIRED_W-1:0] wired_i,
    input  logic [SPAN_W-1:0]  rem_i,
    output logic               legal_o,
    output logic [SPAN_W-1:0]  span_o,
    output logic [IDX_W-1:0]   index_o
);

    localparam int unsigned SUM_W = ((SPAN_W > WIRED_W) ? SPAN_W : WIRED_W) + 1;

    logic [SUM_W-1:0] sum;

    always_comb begin
        legal_o = (int'(wired_i) < int'(TLB_SIZE));
        span_o  = legal_o ? SPAN_W'(int'(TLB_SIZE) - int'(wired_i)) : SPAN_W'(1);
        sum     = SUM_W'(rem_i) + SUM_W'(wired_i);
        index_o = legal_o ? IDX_W'(sum) : IDX_W'(TLB_SIZE - 1);
    end

endmodule

// File: rtl/tlb_rand_index.sv
module tlb_rand_index
    import tlb_rand_pkg::*;
#(
    parameter int unsigned TLB_SIZE = 16,
    parameter int unsigned WIRED_W  = 5,
    localparam int unsigned IDX_W   = (TLB_SIZE > 1) ? $clog2(TLB_SIZE) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_i,
    input  logic [WIRED_W-1:0] wired_i,
    output logic [IDX_W-1:0]   index_o,
    output logic               valid_o
);

    localparam int unsigned SPAN_W = $clog2(TLB_SIZE + 1);

    rnd_state_e         state_q;
    rnd_state_e         state_d;
    logic [SEED_W-1:0]  seed_q;
    logic [SEED_W-1:0]  seed_next;
    logic [WIRED_W-1:0] wired_q;
    logic               accept;
    logic               legal;
    logic               div_load;
    logic               div_last;
    logic [SPAN_W-1:0]  span;
    logic [SPAN_W-1:0]  rem;
    logic [IDX_W-1:0]   mapped;

    assign accept   = (state_q == ST_IDLE) && req_i;
    assign div_load = (state_q == ST_LOAD) && legal;

    tlb_rand_lcg #(
        .W    (SEED_W),
        .MULT (LCG_MULT),
        .INC  (LCG_INC)
    ) lcg_i (
        .seed_i      (seed_q),
        .seed_next_o (seed_next)
    );

    tlb_rand_map #(
        .TLB_SIZE (TLB_SIZE),
        .WIRED_W  (WIRED_W),
        .SPAN_W   (SPAN_W),
        .IDX_W    (IDX_W)
    ) map_i (
        .wired_i (wired_q),
        .rem_i   (rem),
        .legal_o (legal),
        .span_o  (span),
        .index_o (mapped)
    );

    tlb_rand_moddiv #(
        .NUM_W (HALF_W),
        .DEN_W (SPAN_W)
    ) div_i (
        .clk    (clk),
        .rst    (rst),
        .load_i (div_load),
        .num_i  (seed_q[SEED_W-1:HALF_W]),
        .den_i  (span),
        .last_o (div_last),
        .rem_o  (rem)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_i) state_d = ST_LOAD;
            ST_LOAD:   state_d = legal ? ST_DIVIDE : ST_FINISH;
            ST_DIVIDE: if (div_last) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Generator state and sampled wired count, touched only on acceptance
    always_ff @(posedge clk) begin
        if (rst) begin
            seed_q  <= '0;
            wired_q <= '0;
        end else if (accept) begin
            seed_q  <= seed_next;
            wired_q <= wired_i;
        end
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o <= 1'b0;
            index_o <= '0;
        end else begin
            valid_o <= (state_q == ST_FINISH);
            if (state_q == ST_FINISH) index_o <= mapped;
        end
    end

endmodule

// File: rtl/tlb_rand_index_chk.sv
module tlb_rand_index_chk
    import tlb_rand_pkg::*;
#(
    parameter int unsigned TLB_SIZE = 16,
    parameter int unsigned WIRED_W  = 5,
    parameter int unsigned IDX_W    = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               req_i,
    input logic [IDX_W-1:0]   index_o,
    input logic               valid_o,
    input logic [WIRED_W-1:0] wired_q,
    input logic [SEED_W-1:0]  seed_q,
    input rnd_state_e         state_q
);

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (seed_q == '0 && !valid_o && index_o == '0));

    p_step_only_on_accept_r8: assert property (@(posedge clk) disable iff (rst)
        !(state_q == ST_IDLE && req_i) |=> $stable(seed_q));

    p_index_in_range_r4: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (int'(index_o) <= int'(TLB_SIZE) - 1 &&
                     (int'(wired_q) >= int'(TLB_SIZE) || index_o >= IDX_W'(wired_q))));

    p_illegal_wired_top_r5: assert property (@(posedge clk) disable iff (rst)
        (valid_o && int'(wired_q) >= int'(TLB_SIZE)) |-> int'(index_o) == int'(TLB_SIZE) - 1);

    p_single_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    p_valid_after_finish_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(valid_o) |-> $past(state_q) == ST_FINISH);

    p_wired_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        state_q != ST_IDLE |=> $stable(wired_q));

endmodule

bind tlb_rand_index tlb_rand_index_chk #(
    .TLB_SIZE (TLB_SIZE),
    .WIRED_W  (WIRED_W),
    .IDX_W    (IDX_W)
) chk_i (
    .clk     (clk),
    .rst     (rst),
    .req_i   (req_i),
    .index_o (index_o),
    .valid_o (valid_o),
    .wired_q (wired_q),
    .seed_q  (seed_q),
    .state_q (state_q)
);

// File: tb/tlb_rand_index_tb_top.sv
module tlb_rand_index_tb_top;

    localparam int TLB     = 16;
    localparam int LAT_DIV = 18;
    localparam int LAT_BYP = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_i = 1'b0;
    logic [4:0] wired_i = '0;
    logic [3:0] index_o;
    logic       valid_o;

    int checks = 0;
    int errors = 0;
    logic [31:0] m_seed = '0;

    always #10 clk = ~clk;

    tlb_rand_index #(.TLB_SIZE(TLB), .WIRED_W(5)) dut_i (
        .clk     (clk),
        .rst     (rst),
        .req_i   (req_i),
        .wired_i (wired_i),
        .index_o (index_o),
        .valid_o (valid_o)
    );

    function automatic logic [31:0] step_seed(logic [31:0] s);
        return s * 32'd314159 + 32'd1;
    endfunction

    function automatic int exp_index(logic [31:0] s, int w);
        if (w >= TLB) return TLB - 1;
        return (int'(s[31:16]) % (TLB - w)) + w;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // One request; optional noise request with a different wired value mid-divide.
    task automatic run_req(input int w, input bit noise, input int w_noise);
        int cnt;
        int lat;
        int exp;
        m_seed = step_seed(m_seed);
        exp = exp_index(m_seed, w);
        lat = (w >= TLB) ? LAT_BYP : LAT_DIV;
        @(negedge clk);
        req_i   = 1'b1;
        wired_i = 5'(w);
        @(negedge clk);
        req_i = 1'b0;
        cnt = 0;
        while (!valid_o && cnt < 40) begin
            @(negedge clk);
            cnt++;
            if (noise && lat == LAT_DIV && cnt == 3) begin
                req_i   = 1'b1;
                wired_i = 5'(w_noise);
            end
            if (cnt == 5) req_i = 1'b0;
        end
        if (w >= TLB) chk("R5 latency", cnt, lat);
        else          chk("R6 latency", cnt, lat);
        if (w >= TLB) chk("R5 index", int'(index_o), exp);
        else if (noise) chk("R9 index with wired change", int'(index_o), exp);
        else          chk("R3 index", int'(index_o), exp);
        chk("R4 index in range", int'(int'(index_o) <= TLB - 1 &&
            (w >= TLB || int'(index_o) >= w)), 1);
        @(negedge clk);
        chk("R7 pulse ends", int'(valid_o), 0);
        if (noise) begin
            repeat (25) begin
                @(negedge clk);
                if (valid_o) chk("R8 no pulse from busy request", 1, 0);
            end
        end
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        chk("R1 valid after reset", int'(valid_o), 0);
        chk("R1 index after reset", int'(index_o), 0);
        rst = 1'b0;

        // Directed: first values from a zeroed state (R2)
        run_req(0, 1'b0, 0);                 // state 1 -> index 0
        chk("R2 first index", int'(index_o), 0);
        run_req(0, 1'b0, 0);                 // state 314160 -> candidate 4
        chk("R2 second index", int'(index_o), 4);
        run_req(TLB - 1, 1'b0, 0);           // span of one
        run_req(TLB, 1'b0, 0);               // illegal boundary
        run_req(31, 1'b0, 0);                // illegal maximum
        run_req(3, 1'b1, 12);                // busy request and wired change
        run_req(3, 1'b0, 0);                 // sequence shows no extra step (R8)

        // Reset in the middle of a computation restores the zero state (R1)
        @(negedge clk);
        req_i = 1'b1; wired_i = 5'd2;
        @(negedge clk);
        req_i = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 valid during reset", int'(valid_o), 0);
        rst = 1'b0;
        m_seed = '0;
        run_req(0, 1'b0, 0);
        chk("R1 state restarted", int'(index_o), 0);

        // Constrained random mix
        for (int i = 0; i < 80; i++) begin
            int w;
            bit nz;
            w  = ($urandom_range(0, 9) == 0) ? int'($urandom_range(TLB, 31))
                                             : int'($urandom_range(0, TLB - 1));
            nz = ($urandom_range(0, 3) == 0);
            run_req(w, nz, int'($urandom_range(0, 31)));
        end

        summary();
        $finish;
    end

endmodule